// File: doc/BRIEF.md
# Serial Receive Character Queue with Line Status

This block sits between a serial receiver and a register-read bus. The receiver pushes each finished character together with three error tags (break, framing, parity). The characters are queued in order, and software pops them one at a time by reading the receive holding register.

A separate status read returns a line status byte. Its per-character error bits come from the tags of the character that will be popped next. A sticky summary bit reports whether any tagged character is still queued anywhere. The byte also carries data-ready and overrun flags, and two transmitter-idle indications taken straight from the transmit side's occupancy inputs.

A status read never consumes a character. A push that arrives while the queue is full is dropped and recorded as an overrun. The next status read clears that record.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty, the error summary and overrun are clear, and with both transmitter inputs high the status byte reads 0x60.
- R2: Characters leave in the order they were accepted. Up to DEPTH characters can be held. While the queue is non-empty, `rhr_data` shows the oldest character, and a holding-register read (`rhr_rd`) removes it.
- R3: Status bit 4 is the break tag, bit 3 the framing tag and bit 2 the parity tag of the oldest queued character. All three read 0 while the queue is empty.
- R4: A status read (`lsr_rd`) never removes a character and never changes `rhr_data`.
- R5: Status bit 7 is 1 exactly while at least one queued character has any tag set. A push and a pop in the same cycle update it by their net effect.
- R6: Status bit 0 is 1 exactly while at least one character is queued.
- R7: A push while the queue is full, with no pop in the same cycle, is discarded and sets status bit 1. A status read clears bit 1 from the next cycle on. A new overrun in the same cycle as a status read leaves bit 1 set.
- R8: Status bit 5 equals `thr_empty`. Status bit 6 equals `thr_empty` AND `tsr_empty`.
- R9: A character pushed with its break tag set is stored with data 0x00, whatever `push_data` carries.
- R10: A holding-register read while the queue is empty changes nothing, and `rhr_data` keeps showing the last character popped (0x00 if none has been popped since reset).
- R11: A push while the queue is full is accepted when a pop happens in the same cycle, and the occupancy stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_valid | input | 1 | Receiver offers a character this cycle |
| push_data | input | 8 | Received character |
| push_brk | input | 1 | Break tag of the offered character |
| push_frm | input | 1 | Framing-error tag of the offered character |
| push_par | input | 1 | Parity-error tag of the offered character |
| rhr_rd | input | 1 | Holding-register read strobe; pops the oldest character |
| lsr_rd | input | 1 | Status read strobe; clears the overrun flag |
| thr_empty | input | 1 | Transmit holding register is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rhr_data | output | 8 | Oldest character, or the last popped character when the queue is empty |
| lsr_data | output | 8 | Line status byte |

## Verification
Two events can land in the same cycle. The first pair is an overrun and the status read that clears the overrun flag. The second pair is a push and a pop that both change the error-tag count. The bench drives a long arithmetic pattern in which push, pop and status-read strobes repeat at co-prime periods. This keeps an 8-deep queue near full, so dropped pushes coincide with status reads and with pops, and tagged and untagged characters enter and leave in the same cycle. A bench-side queue model predicts every field of the status byte and the head character after each cycle. A directed sequence also forces an overrun in the same cycle as a status read, and then checks that bit 1 is still set.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxs_entry_t;

  function automatic logic rxs_tagged(input rxs_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction

endpackage

// File: rtl/rxs_rst_sync.sv
module rxs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rxs_store.sv
module rxs_store
  import rxs_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  rxs_entry_t    push_entry,
  input  logic          pop_req,
  output logic          push_fire,
  output logic          pop_fire,
  output logic          full,
  output logic          empty,
  output rxs_entry_t    head_entry,
  output logic [7:0]    out_data,
  output logic [CW-1:0] occupancy
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX = AW'(DEPTH - 1);

  rxs_entry_t    mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] occ_q, occ_d;
  logic [7:0]    last_q, last_d;

  assign full       = (occ_q == DEPTH_C);
  assign empty      = (occ_q == '0);
  assign pop_fire   = pop_req && !empty;
  assign push_fire  = push_req && (!full || pop_fire);
  assign head_entry = mem[rd_ptr_q];
  assign out_data   = empty ? last_q : head_entry.data;
  assign occupancy  = occ_q;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    occ_d    = occ_q;
    last_d   = last_q;
    if (pop_fire) begin
      rd_ptr_d = (rd_ptr_q == LAST_IX) ? '0 : rd_ptr_q + 1'b1;
      last_d   = head_entry.data;
    end
    if (push_fire) begin
      wr_ptr_d = (wr_ptr_q == LAST_IX) ? '0 : wr_ptr_q + 1'b1;
    end
    case ({push_fire, pop_fire})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      occ_q    <= '0;
      last_q   <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      occ_q    <= occ_d;
      last_q   <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) begin
      mem[wr_ptr_q] <= push_entry;
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= DEPTH_C) else $error("occupancy above depth"); // R2

  AST_FULL_PAIR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && pop_req) |=> full) else $error("full push+pop lost a slot"); // R11

endmodule

// File: rtl/rxs_errcount.sv
module rxs_errcount #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] err_cnt,
  output logic          any_err
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc ^ dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign err_cnt = cnt_q;
  assign any_err = (cnt_q != '0);

  AST_ERRCNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> (cnt_q != '0)) else $error("error count underflow"); // R5

endmodule

// File: rtl/rxs_status.sv
module rxs_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_set,
  input  logic       status_rd,
  input  logic       any_err,
  input  logic       brk_tag,
  input  logic       frm_tag,
  input  logic       par_tag,
  input  logic       thr_empty,
  input  logic       tsr_empty,
  input  logic       not_empty,
  output logic [7:0] status
);

  logic ovr_q, ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set) begin
      ovr_d = 1'b1;
    end else if (status_rd) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    status[7] = any_err;
    status[6] = thr_empty & tsr_empty;
    status[5] = thr_empty;
    status[4] = not_empty & brk_tag;
    status[3] = not_empty & frm_tag;
    status[2] = not_empty & par_tag;
    status[1] = ovr_q;
    status[0] = not_empty;
  end

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> status[1]) else $error("overrun not recorded"); // R7

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovr_set) |=> !status[1]) else $error("overrun not cleared"); // R7

  AST_TX_IDLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[5]) else $error("shift idle without holding idle"); // R8

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  input  logic       push_brk,
  input  logic       push_frm,
  input  logic       push_par,
  input  logic       rhr_rd,
  input  logic       lsr_rd,
  input  logic       thr_empty,
  input  logic       tsr_empty,
  output logic [7:0] rhr_data,
  output logic [7:0] lsr_data
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_i_n;
  rxs_entry_t    in_entry;
  rxs_entry_t    head;
  logic          push_fire, pop_fire, full, empty;
  logic [CW-1:0] occ;
  logic [CW-1:0] err_cnt;
  logic          any_err;
  logic          ovr_set;

  rxs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    in_entry.brk  = push_brk;
    in_entry.frm  = push_frm;
    in_entry.par  = push_par;
    in_entry.data = push_brk ? 8'h00 : push_data;
  end

  rxs_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .push_req   (push_valid),
    .push_entry (in_entry),
    .pop_req    (rhr_rd),
    .push_fire  (push_fire),
    .pop_fire   (pop_fire),
    .full       (full),
    .empty      (empty),
    .head_entry (head),
    .out_data   (rhr_data),
    .occupancy  (occ)
  );

  rxs_errcount #(.DEPTH(DEPTH)) u_err (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .inc     (push_fire && rxs_tagged(in_entry)),
    .dec     (pop_fire && rxs_tagged(head)),
    .err_cnt (err_cnt),
    .any_err (any_err)
  );

  assign ovr_set = push_valid && !push_fire;

  rxs_status u_stat (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ovr_set   (ovr_set),
    .status_rd (lsr_rd),
    .any_err   (any_err),
    .brk_tag   (head.brk),
    .frm_tag   (head.frm),
    .par_tag   (head.par),
    .thr_empty (thr_empty),
    .tsr_empty (tsr_empty),
    .not_empty (!empty),
    .status    (lsr_data)
  );

  AST_ERR_WITHIN_OCC: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_cnt <= occ) else $error("more tagged entries than entries"); // R5

  AST_STATUS_NO_POP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rhr_rd && !push_valid) |=> $stable(occ)) else $error("status read moved the queue"); // R4

  AST_EMPTY_NO_TAGS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (occ == '0) |-> (lsr_data[4:2] == 3'b000)) else $error("tags shown while empty"); // R3

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    ovr_set |-> full) else $error("push dropped while space left"); // R7

endmodule

// File: tb/sim_rx_status_fifo.sv
`timescale 1ns/1ps
module sim_rx_status_fifo;

  localparam int TD = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_valid, push_brk, push_frm, push_par;
  logic [7:0] push_data;
  logic       rhr_rd, lsr_rd, thr_empty, tsr_empty;
  logic [7:0] rhr_data, lsr_data;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  logic [10:0] mq [TD];
  int          m_rd, m_wr, m_cnt;
  bit          m_ovr;
  logic [7:0]  m_last;

  always #4 clk = ~clk;

  rx_status_fifo #(.DEPTH(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
    .rhr_rd(rhr_rd), .lsr_rd(lsr_rd), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
    .rhr_data(rhr_data), .lsr_data(lsr_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      misses = misses + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      misses = misses + 1;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int errs = 0;
    logic [10:0] h;
    for (int k = 0; k < m_cnt; k++) begin
      if (mq[(m_rd + k) % TD][10:8] != 3'b000) errs++;
    end
    h = mq[m_rd];
    chk("R2 head data", rhr_data, (m_cnt > 0) ? h[7:0] : m_last);
    chk("R6 data ready", {7'b0, lsr_data[0]}, {7'b0, m_cnt > 0});
    chk("R7 overrun", {7'b0, lsr_data[1]}, {7'b0, m_ovr});
    chk("R3 head tags", {5'b0, lsr_data[4:2]}, (m_cnt > 0) ? {5'b0, h[10:8]} : 8'h00);
    chk("R8 tx idle", {6'b0, lsr_data[6:5]}, {6'b0, thr_empty & tsr_empty, thr_empty});
    chk("R5 error summary", {7'b0, lsr_data[7]}, {7'b0, errs != 0});
  endtask

  task automatic step(input bit pv, input logic [7:0] d, input bit b, input bit f,
                      input bit p, input bit rr, input bit lr);
    bit pop, acc;
    push_valid = pv; push_data = d; push_brk = b; push_frm = f; push_par = p;
    rhr_rd = rr; lsr_rd = lr;
    @(posedge clk);
    pop = rr && (m_cnt > 0);
    acc = pv && ((m_cnt < TD) || pop);
    if (pv && !acc) m_ovr = 1'b1;
    else if (lr) m_ovr = 1'b0;
    if (pop) begin
      m_last = mq[m_rd][7:0];
      m_rd = (m_rd + 1) % TD;
      m_cnt = m_cnt - 1;
    end
    if (acc) begin
      mq[m_wr] = {b, f, p, (b ? 8'h00 : d)}; // R9 break stores 0x00
      m_wr = (m_wr + 1) % TD;
      m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    push_valid = 1'b0; rhr_rd = 1'b0; lsr_rd = 1'b0;
    check_all();
  endtask

  initial begin
    rst_n = 1'b0;
    push_valid = 0; push_data = 0; push_brk = 0; push_frm = 0; push_par = 0;
    rhr_rd = 0; lsr_rd = 0; thr_empty = 1; tsr_empty = 1;
    m_rd = 0; m_wr = 0; m_cnt = 0; m_ovr = 0; m_last = 8'h00;
    for (int k = 0; k < TD; k++) mq[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state with transmitter idle
    chk("R1 reset status", lsr_data, 8'h60);
    chk("R1 reset data", rhr_data, 8'h00);

    // R8: all transmitter input combinations
    for (int t = 0; t < 4; t++) begin
      thr_empty = t[0]; tsr_empty = t[1];
      #1 check_all();
    end
    thr_empty = 1; tsr_empty = 1;

    // R10: pop on empty queue changes nothing
    step(0, 8'h00, 0, 0, 0, 1, 0);

    // R9 / R3 / R5: fill with every tag combination, break data forced to zero
    for (int i = 0; i < TD; i++) step(1, 8'(8'hA5 + i * 37), i[2], i[1], i[0], 0, 0);

    // R7: push while full is dropped; overrun then read in same cycle as new overrun
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0, 1);   // R7 set wins over read
    step(0, 8'h00, 0, 0, 0, 0, 1);   // R7 read clears
    // R4: status reads leave the queue alone
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0, 0, 0, 1);

    // R11: push with pop while full
    step(1, 8'h3C, 0, 1, 0, 1, 0);

    // R2: drain in order, then R10 reads while empty
    for (int i = 0; i < TD; i++) step(0, 8'h00, 0, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 0, 1, 1);

    // Concurrent sweep: co-prime strobe periods keep the queue near full
    for (int i = 0; i < 6000; i++) begin
      thr_empty = ((i / 11) % 2) == 0;
      tsr_empty = ((i / 13) % 3) != 0;
      step((i % 3) != 0, 8'(i * 29 + 7),
           ((i % 17) == 0), ((i % 5) == 1), ((i % 7) == 2),
           ((i % 5) == 0) || ((i % 9) == 4) || ((i / 700) % 2 == 1 && (i % 2) == 0),
           ((i % 4) == 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule